// File: doc/BRIEF.md
# Slot-Masked TDM Serial Receiver

This block receives a time-division-multiplexed serial audio stream. A bit clock, a frame sync and a data line arrive as ordinary inputs in the system clock domain. The block finds the rising edges of the bit clock, shifts data in MSB first, and splits each frame into fixed-length slots, with slot 0 starting on the bit where frame sync is high. When a word is complete, a per-slot enable mask decides whether the word is kept or discarded.

Kept words go into an eight-deep receive FIFO. In two-channel mode they are steered in turn into two independent FIFOs, starting with FIFO 0. Only kept words move the steering pointer. Each FIFO has its own read port, a threshold flag with an interrupt request, and a sticky overrun flag.

Each FIFO read port uses valid/ready. The head word is shown while valid is high. It is removed on a clock edge where valid and ready are both high, and it stays unchanged while ready is low. The receive side cannot be stalled. A word that arrives for a full FIFO is dropped and counted as an overrun instead of applying back-pressure.

Top module: `tdm_slot_rx`

## Requirements
- R1: Data is sampled on each rising edge of the bit clock, MSB first. A word holds `wlen_i`+1 bits (8 to 32) and is presented right-aligned, with the upper bits zero.
- R2: Nothing is stored while `rx_en_i` is low. After `rx_en_i` rises, capture starts at the first bit sampled with frame sync high. Bits before that bit are ignored.
- R3: Bit k of `slot_mask_i` enables slot k. Slot 0 starts at the bit sampled with frame sync high. A word from a disabled slot, or from a slot past `SLOTS`-1, is discarded.
- R4: With `two_ch_i` low, every kept word goes to channel 0, and channel 1 receives nothing.
- R5: With `two_ch_i` high, kept words alternate between channels, starting at channel 0. Masked slots do not move the alternation.
- R6: While `rx_en_i` is low, the steering pointer returns to channel 0.
- R7: Each channel is a first-in first-out queue of `DEPTH` words. The head word stays stable while valid is high and ready is low.
- R8: `full_o[c]` is high when channel c holds at least `thr_i` words. `irq_o[c]` equals `full_o[c]` AND `irq_en_i[c]`.
- R9: A word steered to a channel that already holds `DEPTH` words is dropped and sets `ovr_o[c]`. The steering pointer still advances. `ovr_o[c]` stays set until `rx_en_i` is low.
- R10: After reset, all valid, full, overrun and interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk_i | input | 1 | Serial bit clock; data is sampled on its rising edge |
| fs_i | input | 1 | Frame sync, high on the first bit of slot 0 |
| sd_i | input | 1 | Serial data |
| rx_en_i | input | 1 | Receive enable |
| two_ch_i | input | 1 | Two-channel steering enable |
| wlen_i | input | LEN_W | Word length minus one |
| slot_mask_i | input | SLOTS | Per-slot receive enable |
| thr_i | input | CNT_W | Fill threshold for the full flags |
| irq_en_i | input | 2 | Interrupt enable per channel |
| rd_ready_i | input | 2 | Read ready per channel |
| rd_valid_o | output | 2 | Head word valid per channel |
| rd_data_o | output | 2*MAX_W | Head word; channel c at bits [c*MAX_W +: MAX_W] |
| full_o | output | 2 | Fill level at or above the threshold |
| ovr_o | output | 2 | Sticky overrun per channel |
| irq_o | output | 2 | Interrupt request per channel |

## Verification
The bench builds the block with `SLOTS`=4 and `DEPTH`=4, keeping `MAX_W` at 32. Short frames therefore reach the frame end and the slots beyond it quickly, and a single unread frame fills a FIFO. A second frame drives it into overrun, including the two-channel case where the pointer keeps stepping past a full channel. Word lengths of 8, 12 and 32 bits are selected at run time, so the full sampling range is covered without rebuilding.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
  localparam int unsigned NCH = 2;
  typedef enum logic {CH_ZERO = 1'b0, CH_ONE = 1'b1} ch_t;
endpackage

// File: rtl/tdm_bit_deser.sv
module tdm_bit_deser #(
  parameter int SLOTS = 8,
  parameter int MAX_W = 32,
  localparam int LEN_W = $clog2(MAX_W),
  localparam int SLOT_W = $clog2(SLOTS),
  localparam int SLOT_CW = $clog2(SLOTS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bclk_i,
  input  logic               fs_i,
  input  logic               sd_i,
  input  logic               rx_en_i,
  input  logic [LEN_W-1:0]   wlen_i,
  output logic               word_vld_o,
  output logic [SLOT_W-1:0]  word_slot_o,
  output logic [MAX_W-1:0]   word_o
);
  logic               bclk_q;
  logic               samp;
  logic [LEN_W-1:0]   bit_q, bit_cur;
  logic [SLOT_CW-1:0] slot_q, slot_cur;
  logic               armed_q, armed_nxt;
  logic [MAX_W-1:0]   sh_q, sh_nxt, len_mask;
  logic               last_bit, in_frame;

  // a rising bit-clock edge seen in the system clock domain
  assign samp = bclk_i & ~bclk_q;

  always_comb begin
    bit_cur   = fs_i ? '0 : bit_q;
    slot_cur  = fs_i ? '0 : slot_q;
    sh_nxt    = fs_i ? {{(MAX_W-1){1'b0}}, sd_i} : {sh_q[MAX_W-2:0], sd_i};
    armed_nxt = rx_en_i & (armed_q | fs_i);
    last_bit  = (bit_cur == wlen_i);
    in_frame  = (slot_cur < SLOT_CW'(SLOTS));
    for (int i = 0; i < MAX_W; i++) len_mask[i] = (i <= int'(wlen_i));
  end

  assign word_vld_o  = samp & armed_nxt & last_bit & in_frame;
  assign word_slot_o = slot_cur[SLOT_W-1:0];
  assign word_o      = sh_nxt & len_mask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q  <= 1'b0;
      bit_q   <= '0;
      slot_q  <= '0;
      armed_q <= 1'b0;
      sh_q    <= '0;
    end else begin
      bclk_q <= bclk_i;
      if (samp) begin
        sh_q    <= sh_nxt;
        armed_q <= armed_nxt;
        if (last_bit) begin
          bit_q  <= '0;
          slot_q <= in_frame ? slot_cur + 1'b1 : slot_cur;
        end else begin
          bit_q  <= bit_cur + 1'b1;
          slot_q <= slot_cur;
        end
      end else begin
        armed_q <= armed_q & rx_en_i;
      end
    end
  end

  AST_NO_WORD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |-> !word_vld_o); // R2
endmodule

// File: rtl/tdm_slot_router.sv
module tdm_slot_router
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int MAX_W = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_vld_i,
  input  logic [SLOT_W-1:0] word_slot_i,
  input  logic [MAX_W-1:0]  word_i,
  input  logic [SLOTS-1:0]  slot_mask_i,
  input  logic              rx_en_i,
  input  logic              two_ch_i,
  output logic [NCH-1:0]    wr_en_o,
  output logic [MAX_W-1:0]  wr_data_o
);
  ch_t  sel_q, target;
  logic keep;

  assign keep      = word_vld_i & slot_mask_i[word_slot_i];
  assign target    = two_ch_i ? sel_q : CH_ZERO;
  assign wr_data_o = word_i;

  for (genvar c = 0; c < NCH; c++) begin : g_wr
    assign wr_en_o[c] = keep & (target == ch_t'(c));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_en_i) sel_q <= CH_ZERO;
    else if (keep && two_ch_i) sel_q <= (sel_q == CH_ZERO) ? CH_ONE : CH_ZERO;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_en_o)); // R5
  AST_SINGLE_CH: assert property (@(posedge clk) disable iff (!rst_n)
    !two_ch_i |-> !wr_en_o[1]); // R4
  AST_PTR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en_i |=> sel_q == CH_ZERO); // R6
  AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_vld_i && !slot_mask_i[word_slot_i]) |-> wr_en_o == '0); // R3
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 32,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             wr_en_i,
  input  logic [WIDTH-1:0] wr_data_i,
  input  logic             rd_ready_i,
  output logic             rd_valid_o,
  output logic [WIDTH-1:0] rd_data_o,
  output logic [CNT_W-1:0] level_o,
  output logic             ovr_o
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] level_q;
  logic             is_full, push, pop, ovr_q;

  assign is_full    = (level_q == CNT_W'(DEPTH));
  assign push       = wr_en_i & ~is_full;
  assign rd_valid_o = (level_q != '0);
  assign pop        = rd_valid_o & rd_ready_i;
  assign rd_data_o  = mem[rd_ptr];
  assign level_o    = level_q;
  assign ovr_o      = ovr_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
      ovr_q   <= 1'b0;
    end else begin
      if (push) wr_ptr <= wr_ptr + 1'b1;
      if (pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({push, pop})
        2'b10:   level_q <= level_q + 1'b1;
        2'b01:   level_q <= level_q - 1'b1;
        default: level_q <= level_q;
      endcase
      if (!run_i) ovr_q <= 1'b0;
      else if (wr_en_i && is_full) ovr_q <= 1'b1;
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= CNT_W'(DEPTH)); // R7
  AST_HOLD_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid_o && !rd_ready_i) |=> (rd_valid_o && $stable(rd_data_o))); // R7
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_q && run_i) |=> ovr_q); // R9
endmodule

// File: rtl/tdm_slot_rx.sv
module tdm_slot_rx
  import tdm_rx_pkg::*;
#(
  parameter int SLOTS = 8,
  parameter int MAX_W = 32,
  parameter int DEPTH = 8,
  localparam int LEN_W = $clog2(MAX_W),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bclk_i,
  input  logic                 fs_i,
  input  logic                 sd_i,
  input  logic                 rx_en_i,
  input  logic                 two_ch_i,
  input  logic [LEN_W-1:0]     wlen_i,
  input  logic [SLOTS-1:0]     slot_mask_i,
  input  logic [CNT_W-1:0]     thr_i,
  input  logic [1:0]           irq_en_i,
  input  logic [1:0]           rd_ready_i,
  output logic [1:0]           rd_valid_o,
  output logic [2*MAX_W-1:0]   rd_data_o,
  output logic [1:0]           full_o,
  output logic [1:0]           ovr_o,
  output logic [1:0]           irq_o
);
  localparam int SLOT_W = $clog2(SLOTS);

  logic              word_vld;
  logic [SLOT_W-1:0] word_slot;
  logic [MAX_W-1:0]  word, wr_data;
  logic [NCH-1:0]    wr_en;

  tdm_bit_deser #(.SLOTS(SLOTS), .MAX_W(MAX_W)) u_deser (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk_i), .fs_i(fs_i), .sd_i(sd_i),
    .rx_en_i(rx_en_i), .wlen_i(wlen_i), .word_vld_o(word_vld),
    .word_slot_o(word_slot), .word_o(word));

  tdm_slot_router #(.SLOTS(SLOTS), .MAX_W(MAX_W)) u_router (
    .clk(clk), .rst_n(rst_n), .word_vld_i(word_vld), .word_slot_i(word_slot),
    .word_i(word), .slot_mask_i(slot_mask_i), .rx_en_i(rx_en_i),
    .two_ch_i(two_ch_i), .wr_en_o(wr_en), .wr_data_o(wr_data));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [CNT_W-1:0] level;
    tdm_rx_fifo #(.DEPTH(DEPTH), .WIDTH(MAX_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .run_i(rx_en_i), .wr_en_i(wr_en[c]),
      .wr_data_i(wr_data), .rd_ready_i(rd_ready_i[c]),
      .rd_valid_o(rd_valid_o[c]), .rd_data_o(rd_data_o[c*MAX_W +: MAX_W]),
      .level_o(level), .ovr_o(ovr_o[c]));
    assign full_o[c] = (level >= thr_i);
    assign irq_o[c]  = full_o[c] & irq_en_i[c];
  end
endmodule

// File: tb/sim_tdm_slot_rx.sv
module sim_tdm_slot_rx;
  localparam int SLOTS = 4;
  localparam int MAX_W = 32;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bclk = 1'b0, fs = 1'b0, sd = 1'b0, rx_en = 1'b0, two_ch = 1'b0;
  logic [4:0] wlen = 5'd7;
  logic [SLOTS-1:0] mask = '0;
  logic [2:0] thr = 3'd4;
  logic [1:0] irq_en = 2'b00, rd_ready = 2'b00;
  logic [1:0] rd_valid, full, ovr, irq;
  logic [2*MAX_W-1:0] rd_data;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tdm_slot_rx #(.SLOTS(SLOTS), .MAX_W(MAX_W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .fs_i(fs), .sd_i(sd),
    .rx_en_i(rx_en), .two_ch_i(two_ch), .wlen_i(wlen), .slot_mask_i(mask),
    .thr_i(thr), .irq_en_i(irq_en), .rd_ready_i(rd_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .full_o(full),
    .ovr_o(ovr), .irq_o(irq));

  // ---------------- reference model ----------------
  logic [31:0] mq0[$], mq1[$];
  logic [31:0] got0[$], got1[$];
  int m_bit, m_slot, bc, sc;
  bit m_arm, m_prevb, m_sel, samp, tgt;
  bit m_ovr[2];
  bit fb[2];
  logic [31:0] m_sh, mword;

  function automatic logic [31:0] wmask(input int w);
    logic [63:0] m = (64'd1 << w) - 64'd1;
    return m[31:0];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mq0.delete(); mq1.delete();
      m_bit = 0; m_slot = 0; m_arm = 0; m_prevb = 0; m_sel = 0;
      m_ovr[0] = 0; m_ovr[1] = 0; m_sh = '0;
    end else begin
      fb[0] = (mq0.size() == DEPTH);
      fb[1] = (mq1.size() == DEPTH);
      if (mq0.size() > 0 && rd_ready[0]) void'(mq0.pop_front());
      if (mq1.size() > 0 && rd_ready[1]) void'(mq1.pop_front());
      samp = bclk && !m_prevb;
      m_prevb = bclk;
      if (!rx_en) begin
        m_arm = 0; m_sel = 0; m_ovr[0] = 0; m_ovr[1] = 0;
      end
      if (samp) begin
        bc = fs ? 0 : m_bit;
        sc = fs ? 0 : m_slot;
        m_sh = fs ? {31'd0, sd} : {m_sh[30:0], sd};
        m_arm = rx_en && (m_arm || fs);
        if (m_arm && bc == int'(wlen) && sc < SLOTS && mask[sc]) begin
          mword = m_sh & wmask(int'(wlen) + 1);
          tgt = two_ch ? m_sel : 1'b0;
          if (two_ch) m_sel = !m_sel;
          if (fb[tgt]) m_ovr[tgt] = 1;
          else if (tgt) mq1.push_back(mword);
          else mq0.push_back(mword);
        end
        if (bc == int'(wlen)) begin
          m_bit = 0;
          m_slot = (sc < SLOTS) ? sc + 1 : sc;
        end else begin
          m_bit = (bc + 1) % 32;
          m_slot = sc;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison and read capture, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R7 valid0", {63'd0, rd_valid[0]}, {63'd0, mq0.size() > 0});
      chk("R7 valid1", {63'd0, rd_valid[1]}, {63'd0, mq1.size() > 0});
      if (mq0.size() > 0) chk("R7 data0", {32'd0, rd_data[31:0]}, {32'd0, mq0[0]});
      if (mq1.size() > 0) chk("R7 data1", {32'd0, rd_data[63:32]}, {32'd0, mq1[0]});
      chk("R8 full0", {63'd0, full[0]}, {63'd0, mq0.size() >= int'(thr)});
      chk("R8 full1", {63'd0, full[1]}, {63'd0, mq1.size() >= int'(thr)});
      chk("R8 irq0", {63'd0, irq[0]}, {63'd0, (mq0.size() >= int'(thr)) && irq_en[0]});
      chk("R8 irq1", {63'd0, irq[1]}, {63'd0, (mq1.size() >= int'(thr)) && irq_en[1]});
      chk("R9 ovr0", {63'd0, ovr[0]}, {63'd0, m_ovr[0]});
      chk("R9 ovr1", {63'd0, ovr[1]}, {63'd0, m_ovr[1]});
      if (rd_valid[0] && rd_ready[0]) got0.push_back(rd_data[31:0]);
      if (rd_valid[1] && rd_ready[1]) got1.push_back(rd_data[63:32]);
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  function automatic logic [31:0] gen(input int fid, input int s, input int w);
    logic [31:0] v = 32'hA5C3_1E97 ^ (32'(fid) * 32'h0101_0101);
    v = v + 32'(s) * 32'h1357_9BDF;
    return v & wmask(w);
  endfunction

  task automatic drive_bit(input logic f, input logic d);
    bclk = 1'b0; fs = f; sd = d;
    tick(2);
    bclk = 1'b1;
    tick(2);
  endtask

  task automatic send_frame(input int fid, input int w);
    logic [31:0] v;
    for (int s = 0; s < SLOTS; s++) begin
      v = gen(fid, s, w);
      for (int b = w - 1; b >= 0; b--) drive_bit(s == 0 && b == w - 1, v[b]);
    end
    bclk = 1'b0; fs = 1'b0;
    tick(12);
  endtask

  task automatic expect_ch(input int c, input string tag, input logic [31:0] exp[$]);
    if (c == 0) begin
      chk({tag, " count0"}, 64'(got0.size()), 64'(exp.size()));
      for (int i = 0; i < exp.size() && i < got0.size(); i++) chk({tag, " word0"}, {32'd0, got0[i]}, {32'd0, exp[i]});
      got0.delete();
    end else begin
      chk({tag, " count1"}, 64'(got1.size()), 64'(exp.size()));
      for (int i = 0; i < exp.size() && i < got1.size(); i++) chk({tag, " word1"}, {32'd0, got1[i]}, {32'd0, exp[i]});
      got1.delete();
    end
  endtask

  initial begin
    logic [31:0] e0[$], e1[$];
    tick(5);
    rst_n = 1'b1;
    tick(1);
    // R10 reset state
    chk("R10 valid", {62'd0, rd_valid}, 64'd0);
    chk("R10 full", {62'd0, full}, 64'd0);
    chk("R10 ovr", {62'd0, ovr}, 64'd0);
    chk("R10 irq", {62'd0, irq}, 64'd0);

    // R2: disabled receiver stores nothing; arming waits for frame sync
    rd_ready = 2'b11; mask = 4'b1111;
    send_frame(0, 8);
    e0 = {}; expect_ch(0, "R2 idle", e0);
    rx_en = 1'b1;
    for (int i = 0; i < 5; i++) drive_bit(1'b0, 1'b1);
    send_frame(1, 8);
    e0 = {gen(1,0,8), gen(1,1,8), gen(1,2,8), gen(1,3,8)};
    expect_ch(0, "R2 armed", e0);
    e1 = {}; expect_ch(1, "R4 single", e1);

    // R3: slot mask, slots 0 and 2
    mask = 4'b0101;
    send_frame(2, 8);
    e0 = {gen(2,0,8), gen(2,2,8)};
    expect_ch(0, "R3 mask", e0);

    // R1: word lengths 32 and 12
    wlen = 5'd31; mask = 4'b1001;
    send_frame(3, 32);
    e0 = {gen(3,0,32), gen(3,3,32)};
    expect_ch(0, "R1 w32", e0);
    wlen = 5'd11; mask = 4'b1111;
    send_frame(4, 12);
    e0 = {gen(4,0,12), gen(4,1,12), gen(4,2,12), gen(4,3,12)};
    expect_ch(0, "R1 w12", e0);

    // R5: alternation across enabled slots only, continuing over frames
    wlen = 5'd7; two_ch = 1'b1; mask = 4'b1011;
    send_frame(5, 8);
    mask = 4'b1111;
    send_frame(6, 8);
    e0 = {gen(5,0,8), gen(5,3,8), gen(6,1,8), gen(6,3,8)};
    e1 = {gen(5,1,8), gen(6,0,8), gen(6,2,8)};
    expect_ch(0, "R5 alt", e0);
    expect_ch(1, "R5 alt", e1);

    // R6: pointer home after enable drop (pointer was on channel 1)
    rx_en = 1'b0; tick(3); rx_en = 1'b1;
    mask = 4'b0001;
    send_frame(7, 8);
    e0 = {gen(7,0,8)}; e1 = {};
    expect_ch(0, "R6 home", e0);
    expect_ch(1, "R6 home", e1);

    // R8 / R9: threshold, interrupt, overrun
    rd_ready = 2'b00; two_ch = 1'b0; thr = 3'd3; irq_en = 2'b01;
    rx_en = 1'b0; tick(2); rx_en = 1'b1;
    mask = 4'b1111;
    send_frame(8, 8);
    chk("R8 full0 set", {63'd0, full[0]}, 64'd1);
    chk("R8 irq0 set", {63'd0, irq[0]}, 64'd1);
    chk("R9 no ovr yet", {63'd0, ovr[0]}, 64'd0);
    send_frame(9, 8);
    chk("R9 ovr0 set", {63'd0, ovr[0]}, 64'd1);
    two_ch = 1'b1;
    send_frame(10, 8);
    chk("R8 full1 below", {63'd0, full[1]}, 64'd0);
    thr = 3'd2; #1;
    chk("R8 full1 at thr", {63'd0, full[1]}, 64'd1);
    chk("R8 irq1 masked", {63'd0, irq[1]}, 64'd0);
    chk("R9 ovr1 clear", {63'd0, ovr[1]}, 64'd0);
    rd_ready = 2'b11;
    tick(12);
    e0 = {gen(8,0,8), gen(8,1,8), gen(8,2,8), gen(8,3,8)};
    e1 = {gen(10,1,8), gen(10,3,8)};
    expect_ch(0, "R7 order", e0);
    expect_ch(1, "R9 ptr adv", e1);
    chk("R9 ovr0 sticky", {63'd0, ovr[0]}, 64'd1);
    rx_en = 1'b0;
    tick(1);
    chk("R9 ovr0 cleared", {63'd0, ovr[0]}, 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule